// File: doc/BRIEF.md
# Chained Time-Slot Serial Sample Port

This block turns each new I/Q sample pair of a sample-producing device into a serial stream on a data line that several devices share toward a DSP. Every device owns the line for one time slot of the frame. A device marks the last bit of its slot with a frame-end strobe. The next device in the chain watches that strobe and takes the line on the following bit period. Line ownership leaves the block as a drive-enable output beside the data bit, and the pad stays outside the block.

One instance works as the frame initiator. In master mode it divides the system clock into a bit clock and issues a one-period frame sync before its first bit. It starts a frame only when a fresh sample is waiting, and it holds off the next frame until every slot of the chain has passed. A downstream instance runs in slave mode and takes its bit clock from outside. It is triggered either by an external frame sync or, with its cascade setting on, by the upstream frame-end. All outputs change on the falling edge of the bit clock, and the frame inputs are sampled on the rising edge.

A new sample is latched into a holding register and sent in the next frame, so a transfer already in progress is never disturbed. A short data-valid pulse, 2 or 4 system-clock cycles long, marks every sample arrival for an edge-triggered interrupt. A sample that replaces one not yet sent sets a sticky overrun flag.

Top module: `tdm_chain_port`

## Requirements
- R1: A slot is 32 bit periods: the 16-bit I word, then the 16-bit Q word, each sent most significant bit first. Data changes after a falling bit-clock edge and is stable at the next rising edge.
- R2: `fe_out` is high during the device's own last (32nd) bit period and low in every other bit period.
- R3: A device with `cascade_en` set drives its first bit in the period right after the period in which `fe_in` was high. Its `sdo_oe` is high for exactly its 32 bit periods, and two chained devices never assert `sdo_oe` in the same clock cycle.
- R4: In master mode without cascade, `fsync_out` is high for exactly one bit period, immediately before the first bit, and no frame starts while no new sample is waiting.
- R5: A master frame lasts the sync period plus CHAIN_SLOTS×32 bit periods, and `fsync_out` stays low through all chain slots of that frame.
- R6: In slave mode all bit timing comes from `sclk_in`, and `sclk_out` is held low.
- R7: `dv_out` goes high in the cycle after `sample_valid` and stays high for 2 clock cycles when `dv_long`=0, or for 4 when `dv_long`=1.
- R8: A sample arriving during a transfer is held and sent in the next frame, and the word being shifted is unchanged.
- R9: A second sample arriving before the held one is sent replaces it, and `overrun` is set and stays set until reset.
- R10: After reset `sdo_oe`, `fe_out`, `fsync_out`, `dv_out` and `overrun` are all 0.
- R11: In master mode `sclk_out` has a period of SCLK_DIV clock cycles. It is low for the first half after each falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (high-speed) clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_mode | input | 1 | 1: generate bit clock and frame sync; 0: take them from outside |
| cascade_en | input | 1 | 1: start on upstream frame-end instead of frame sync |
| dv_long | input | 1 | Data-valid pulse length select: 0 gives 2 cycles, 1 gives 4 |
| sample_valid | input | 1 | One-cycle strobe: new sample on sample_i/sample_q |
| sample_i | input | 16 | In-phase sample word |
| sample_q | input | 16 | Quadrature sample word |
| sclk_in | input | 1 | External bit clock (slave mode) |
| fsync_in | input | 1 | External frame sync (slave mode, no cascade) |
| fe_in | input | 1 | Frame-end from the upstream device |
| sclk_out | output | 1 | Generated bit clock (master mode, else 0) |
| fsync_out | output | 1 | Generated frame sync |
| sdo | output | 1 | Serial data bit |
| sdo_oe | output | 1 | Drive enable for the shared data line |
| fe_out | output | 1 | Frame-end toward the downstream device |
| dv_out | output | 1 | New-sample pulse |
| overrun | output | 1 | Sticky flag: an unsent sample was overwritten |

## Verification
Two instances form a chain: a master initiator and a cascaded slave clocked by the master's bit clock. The decoded shared line is compared with a table of sample pairs whose words are all ones, all zeros, single edge bits and alternating patterns. These values separate bit-order and word-order faults, off-by-one slot boundaries and a handoff that comes one period early or late. Directed runs inject samples in mid-frame, once to show holding and twice to show replacement and the overrun flag. They also leave the master without a sample to show that it stays silent, and they measure the data-valid pulse in both length settings.

// File: rtl/tdm_chain_pkg.sv
package tdm_chain_pkg;

    // Frame sequencer states
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,   // not owning the line, waiting for a trigger
        SEQ_SYNC  = 2'd1,   // master: frame sync period before first bit
        SEQ_SHIFT = 2'd2,   // own slot: driving the shared line
        SEQ_TAIL  = 2'd3    // master: waiting while downstream slots run
    } seq_state_e;

endpackage

// File: rtl/tdm_bit_clock.sv
module tdm_bit_clock #(
    parameter int SCLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic master_mode,
    input  logic sclk_in,
    output logic sclk_out,
    output logic rise_stb,
    output logic fall_stb
);

    localparam int CW       = (SCLK_DIV > 2) ? $clog2(SCLK_DIV) : 1;
    localparam int HALF     = SCLK_DIV / 2;
    localparam logic [CW-1:0] DIV_LAST  = CW'(SCLK_DIV - 1);
    localparam logic [CW-1:0] HALF_LAST = CW'(HALF - 1);
    localparam logic [CW-1:0] HALF_CNT  = CW'(HALF);

    typedef struct packed {
        logic [CW-1:0] div;
        logic          sclk_in;
    } clk_reg_t;

    clk_reg_t st_d, st_q;

    logic m_rise, m_fall, s_rise, s_fall;

    always_comb begin
        st_d         = st_q;
        st_d.div     = (st_q.div == DIV_LAST) ? '0 : st_q.div + 1'b1;
        st_d.sclk_in = sclk_in;

        // master strobes: rising edge mid period, falling at wrap
        m_rise = (st_q.div == HALF_LAST);
        m_fall = (st_q.div == DIV_LAST);
        // slave strobes: edge detect on the external clock
        s_rise = sclk_in & ~st_q.sclk_in;
        s_fall = ~sclk_in & st_q.sclk_in;

        rise_stb = master_mode ? m_rise : s_rise;
        fall_stb = master_mode ? m_fall : s_fall;
        sclk_out = master_mode & (st_q.div >= HALF_CNT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R11: rising and falling strobes never coincide
    a_r11_strobe_excl : assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_stb, fall_stb}));

    // R11: after a master rising strobe the generated clock is high
    a_r11_sclk_high : assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && rise_stb && $stable(master_mode)) |=> sclk_out);

endmodule

// File: rtl/tdm_sample_hold.sv
module tdm_sample_hold #(
    parameter int WORD_W       = 16,
    parameter int DV_SHORT_CYC = 2,
    parameter int DV_LONG_CYC  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_valid,
    input  logic [WORD_W-1:0]   sample_i,
    input  logic [WORD_W-1:0]   sample_q,
    input  logic                dv_long,
    input  logic                take,
    output logic [2*WORD_W-1:0] hold_word,
    output logic                pending,
    output logic                overrun,
    output logic                dv_out
);

    localparam int PAIR_W = 2 * WORD_W;
    localparam int DVW    = $clog2(DV_LONG_CYC + 1);
    localparam logic [DVW-1:0] DV_SHORT = DVW'(DV_SHORT_CYC);
    localparam logic [DVW-1:0] DV_LONG  = DVW'(DV_LONG_CYC);

    typedef struct packed {
        logic [PAIR_W-1:0] word;
        logic              pending;
        logic              overrun;
        logic [DVW-1:0]    dv_cnt;
    } hold_reg_t;

    hold_reg_t st_d, st_q;

    always_comb begin
        st_d = st_q;

        // the sequencer consumes the held pair
        if (take) begin
            st_d.pending = 1'b0;
        end

        if (sample_valid) begin
            st_d.word    = {sample_i, sample_q};
            st_d.pending = 1'b1;
            if (st_q.pending && !take) begin
                st_d.overrun = 1'b1;
            end
        end

        // data-valid pulse counter
        if (sample_valid) begin
            st_d.dv_cnt = dv_long ? DV_LONG : DV_SHORT;
        end else if (st_q.dv_cnt != '0) begin
            st_d.dv_cnt = st_q.dv_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_word = st_q.word;
    assign pending   = st_q.pending;
    assign overrun   = st_q.overrun;
    assign dv_out    = (st_q.dv_cnt != '0);

    // R9: overrun is sticky
    a_r9_overrun_sticky : assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R9: overrun only rises when a sample lands on an unsent one
    a_r9_overrun_cause : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> ($past(sample_valid) && $past(pending)));

    // R7: a data-valid pulse always follows a sample strobe
    a_r7_dv_source : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dv_out) |-> $past(sample_valid));

endmodule

// File: rtl/tdm_frame_seq.sv
module tdm_frame_seq
    import tdm_chain_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int CHAIN_SLOTS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                master_mode,
    input  logic                cascade_en,
    input  logic                fsync_in,
    input  logic                fe_in,
    input  logic                rise_stb,
    input  logic                fall_stb,
    input  logic                pending,
    input  logic [2*WORD_W-1:0] hold_word,
    output logic                take,
    output logic                sdo,
    output logic                sdo_oe,
    output logic                fe_out,
    output logic                fsync_out
);

    localparam int FRAME_BITS = 2 * WORD_W;
    localparam int BCW        = $clog2(FRAME_BITS);
    localparam int TAIL_BITS  = (CHAIN_SLOTS - 1) * FRAME_BITS;
    localparam int TCW        = (TAIL_BITS > 2) ? $clog2(TAIL_BITS) : 1;
    localparam int TAIL_LAST  = (TAIL_BITS > 0) ? TAIL_BITS - 1 : 0;
    localparam logic [BCW-1:0] BIT_LAST = BCW'(FRAME_BITS - 1);
    localparam logic [BCW-1:0] BIT_PREV = BCW'(FRAME_BITS - 2);
    localparam logic [TCW-1:0] TAIL_END = TCW'(TAIL_LAST);

    typedef struct packed {
        seq_state_e            state;
        logic [FRAME_BITS-1:0] shreg;
        logic [BCW-1:0]        bcnt;
        logic [TCW-1:0]        tcnt;
        logic                  trig;
        logic                  sdo;
        logic                  oe;
        logic                  fe;
        logic                  fsync;
    } seq_reg_t;

    seq_reg_t st_d, st_q;
    logic     initiator;

    assign initiator = master_mode & ~cascade_en;

    always_comb begin
        st_d = st_q;
        take = 1'b0;

        // frame inputs are captured on the rising bit-clock edge
        if (rise_stb) begin
            st_d.trig = cascade_en ? fe_in : fsync_in;
        end

        // outputs move on the falling bit-clock edge
        if (fall_stb) begin
            unique case (st_q.state)
                SEQ_IDLE: begin
                    if (initiator) begin
                        if (pending) begin
                            st_d.state = SEQ_SYNC;
                            st_d.shreg = hold_word;
                            st_d.fsync = 1'b1;
                            take       = 1'b1;
                        end
                    end else if (st_q.trig) begin
                        st_d.state = SEQ_SHIFT;
                        st_d.sdo   = hold_word[FRAME_BITS-1];
                        st_d.shreg = {hold_word[FRAME_BITS-2:0], 1'b0};
                        st_d.oe    = 1'b1;
                        st_d.fe    = 1'b0;
                        st_d.bcnt  = '0;
                        st_d.trig  = 1'b0;
                        take       = 1'b1;
                    end
                end
                SEQ_SYNC: begin
                    st_d.state = SEQ_SHIFT;
                    st_d.fsync = 1'b0;
                    st_d.sdo   = st_q.shreg[FRAME_BITS-1];
                    st_d.shreg = {st_q.shreg[FRAME_BITS-2:0], 1'b0};
                    st_d.oe    = 1'b1;
                    st_d.fe    = 1'b0;
                    st_d.bcnt  = '0;
                end
                SEQ_SHIFT: begin
                    if (st_q.bcnt == BIT_LAST) begin
                        st_d.oe   = 1'b0;
                        st_d.fe   = 1'b0;
                        st_d.sdo  = 1'b0;
                        st_d.tcnt = '0;
                        st_d.state = (initiator && (TAIL_BITS > 0)) ? SEQ_TAIL : SEQ_IDLE;
                    end else begin
                        st_d.bcnt  = st_q.bcnt + 1'b1;
                        st_d.sdo   = st_q.shreg[FRAME_BITS-1];
                        st_d.shreg = {st_q.shreg[FRAME_BITS-2:0], 1'b0};
                        st_d.fe    = (st_q.bcnt == BIT_PREV);
                    end
                end
                SEQ_TAIL: begin
                    if (st_q.tcnt == TAIL_END) begin
                        st_d.state = SEQ_IDLE;
                    end else begin
                        st_d.tcnt = st_q.tcnt + 1'b1;
                    end
                end
                default: st_d.state = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{state: SEQ_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo       = st_q.sdo;
    assign sdo_oe    = st_q.oe;
    assign fe_out    = st_q.fe;
    assign fsync_out = st_q.fsync;

    // R2: frame-end is only raised while this device owns the line
    a_r2_fe_owns : assert property (@(posedge clk) disable iff (!rst_n)
        fe_out |-> sdo_oe);

    // R2: the line is released only after a frame-end bit
    a_r2_release_after_fe : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdo_oe) |-> $past(fe_out));

    // R4: the sync period is followed directly by the first data bit
    a_r4_sync_then_data : assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fsync && fall_stb) |=> (sdo_oe && !fsync_out));

    // R3: a non-initiator only takes the line after a captured trigger
    a_r3_start_needs_trig : assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sdo_oe) && !initiator && $stable(initiator)) |-> $past(st_q.trig));

endmodule

// File: rtl/tdm_chain_port.sv
module tdm_chain_port #(
    parameter int WORD_W       = 16,
    parameter int CHAIN_SLOTS  = 2,
    parameter int SCLK_DIV     = 4,
    parameter int DV_SHORT_CYC = 2,
    parameter int DV_LONG_CYC  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              cascade_en,
    input  logic              dv_long,
    input  logic              sample_valid,
    input  logic [WORD_W-1:0] sample_i,
    input  logic [WORD_W-1:0] sample_q,
    input  logic              sclk_in,
    input  logic              fsync_in,
    input  logic              fe_in,
    output logic              sclk_out,
    output logic              fsync_out,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              fe_out,
    output logic              dv_out,
    output logic              overrun
);

    localparam int PAIR_W = 2 * WORD_W;

    logic              rise_stb;
    logic              fall_stb;
    logic              take;
    logic              pending;
    logic [PAIR_W-1:0] hold_word;

    tdm_bit_clock #(
        .SCLK_DIV (SCLK_DIV)
    ) u_clk (
        .clk         (clk),
        .rst_n       (rst_n),
        .master_mode (master_mode),
        .sclk_in     (sclk_in),
        .sclk_out    (sclk_out),
        .rise_stb    (rise_stb),
        .fall_stb    (fall_stb)
    );

    tdm_sample_hold #(
        .WORD_W       (WORD_W),
        .DV_SHORT_CYC (DV_SHORT_CYC),
        .DV_LONG_CYC  (DV_LONG_CYC)
    ) u_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (sample_valid),
        .sample_i     (sample_i),
        .sample_q     (sample_q),
        .dv_long      (dv_long),
        .take         (take),
        .hold_word    (hold_word),
        .pending      (pending),
        .overrun      (overrun),
        .dv_out       (dv_out)
    );

    tdm_frame_seq #(
        .WORD_W      (WORD_W),
        .CHAIN_SLOTS (CHAIN_SLOTS)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .master_mode (master_mode),
        .cascade_en  (cascade_en),
        .fsync_in    (fsync_in),
        .fe_in       (fe_in),
        .rise_stb    (rise_stb),
        .fall_stb    (fall_stb),
        .pending     (pending),
        .hold_word   (hold_word),
        .take        (take),
        .sdo         (sdo),
        .sdo_oe      (sdo_oe),
        .fe_out      (fe_out),
        .fsync_out   (fsync_out)
    );

    // R6: a slave never drives the bit clock
    a_r6_slave_quiet_clk : assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |-> !sclk_out);

endmodule

// File: tb/tdm_chain_port_tb.sv
`timescale 1ns/1ps
module tdm_chain_port_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    // master (initiator) instance
    logic        m_valid = 1'b0;
    logic [15:0] m_i = '0, m_q = '0;
    logic        sclk1, fsync1, sdo1, oe1, fe1, dv1, ovr1;
    // cascaded slave instance
    logic        s_valid = 1'b0;
    logic [15:0] s_i = '0, s_q = '0;
    logic        sclk2, fsync2, sdo2, oe2, fe2, dv2, ovr2;

    tdm_chain_port dut_i (
        .clk(clk), .rst_n(rst_n), .master_mode(1'b1), .cascade_en(1'b0),
        .dv_long(1'b0), .sample_valid(m_valid), .sample_i(m_i), .sample_q(m_q),
        .sclk_in(1'b0), .fsync_in(1'b0), .fe_in(1'b0),
        .sclk_out(sclk1), .fsync_out(fsync1), .sdo(sdo1), .sdo_oe(oe1),
        .fe_out(fe1), .dv_out(dv1), .overrun(ovr1));

    tdm_chain_port dut_s (
        .clk(clk), .rst_n(rst_n), .master_mode(1'b0), .cascade_en(1'b1),
        .dv_long(1'b1), .sample_valid(s_valid), .sample_i(s_i), .sample_q(s_q),
        .sclk_in(sclk1), .fsync_in(1'b0), .fe_in(fe1),
        .sclk_out(sclk2), .fsync_out(fsync2), .sdo(sdo2), .sdo_oe(oe2),
        .fe_out(fe2), .dv_out(dv2), .overrun(ovr2));

    logic line_bit;
    assign line_bit = oe1 ? sdo1 : (oe2 ? sdo2 : 1'b0);

    logic sclk_prev = 1'b0;
    always @(posedge clk) sclk_prev <= sclk1;

    int checks = 0, fails = 0, overlap_cnt = 0;
    always @(negedge clk) if (oe1 && oe2) overlap_cnt++;

    // vectors: {master I, master Q, slave I, slave Q}
    localparam logic [63:0] VEC [5] = '{
        64'hA5A5_5A5A_1234_8001,
        64'hFFFF_0000_0001_8000,
        64'h8000_0001_FFFF_FFFF,
        64'h0F0F_F0F0_C3C3_3C3C,
        64'h7FFE_0002_0000_0000
    };
    localparam logic [63:0] FE1_MASK = 64'h0000_0001_0000_0000;
    localparam logic [63:0] FE2_MASK = 64'h0000_0000_0000_0001;
    localparam logic [63:0] OE1_MASK = 64'hFFFF_FFFF_0000_0000;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_rise();
        do begin
            @(negedge clk);
            m_valid = 1'b0;
        end while (!(sclk1 && !sclk_prev));
    endtask

    task automatic apply(input logic [31:0] mw, input bit use_s, input logic [31:0] sw);
        @(negedge clk);
        m_i = mw[31:16]; m_q = mw[15:0]; m_valid = 1'b1;
        if (use_s) begin
            s_i = sw[31:16]; s_q = sw[15:0]; s_valid = 1'b1;
        end
        @(negedge clk);
        m_valid = 1'b0; s_valid = 1'b0;
    endtask

    // capture one chained frame; optional mid-frame master samples
    task automatic capture(input int inj1, input logic [31:0] w1,
                           input int inj2, input logic [31:0] w2,
                           output logic [63:0] line, output logic [63:0] fe1m,
                           output logic [63:0] fe2m, output logic [63:0] oe1m,
                           output logic [63:0] fsm);
        do wait_rise(); while (!fsync1);
        for (int b = 0; b < 64; b++) begin
            wait_rise();
            line[63-b] = line_bit;
            fe1m[63-b] = fe1;
            fe2m[63-b] = fe2;
            oe1m[63-b] = oe1;
            fsm[63-b]  = fsync1;
            if (b == inj1) begin
                m_i = w1[31:16]; m_q = w1[15:0]; m_valid = 1'b1;
            end
            if (b == inj2) begin
                m_i = w2[31:16]; m_q = w2[15:0]; m_valid = 1'b1;
            end
        end
    endtask

    initial begin : watchdog
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        logic [63:0] line, f1, f2, o1, fs;
        logic [31:0] sa;
        int n, c1, c2;

        repeat (4) @(negedge clk);
        // R10: reset state
        chk({oe1, fe1, fsync1, dv1, ovr1} == 5'b0, "R10 reset outputs",
            {59'b0, oe1, fe1, fsync1, dv1, ovr1}, 64'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({oe1, fe1, fsync1, dv1, ovr1, oe2, fe2} == 7'b0, "R10 idle after reset",
            {57'b0, oe1, fe1, fsync1, dv1, ovr1, oe2, fe2}, 64'h0);
        // R6: slave does not drive a bit clock
        chk(sclk2 == 1'b0, "R6 slave sclk_out low", {63'b0, sclk2}, 64'h0);

        // R11: bit clock period
        wait_rise();
        n = 0;
        do begin @(negedge clk); n++; end while (!(sclk1 && !sclk_prev));
        chk(n == 4, "R11 sclk period", 64'(n), 64'd4);

        // vector table: chained frames
        for (int v = 0; v < 5; v++) begin
            apply(VEC[v][63:32], 1'b1, VEC[v][31:0]);
            capture(-1, '0, -1, '0, line, f1, f2, o1, fs);
            chk(line == VEC[v], "R1/R3/R6 line data", line, VEC[v]);
            chk(f1 == FE1_MASK, "R2 master frame-end", f1, FE1_MASK);
            chk(f2 == FE2_MASK, "R2/R3 slave frame-end", f2, FE2_MASK);
            chk(o1 == OE1_MASK, "R3 master ownership", o1, OE1_MASK);
            chk(fs == 64'h0, "R5 no sync inside frame", fs, 64'h0);
        end

        // R8: sample held during transfer
        sa = 32'h3333_4444;
        apply(32'h1111_2222, 1'b1, sa);
        capture(10, 32'h5555_6666, -1, '0, line, f1, f2, o1, fs);
        chk(line == {32'h1111_2222, sa}, "R8 frame not corrupted", line, {32'h1111_2222, sa});
        capture(-1, '0, -1, '0, line, f1, f2, o1, fs);
        chk(line == {32'h5555_6666, sa}, "R8 held sample sent", line, {32'h5555_6666, sa});
        chk(ovr1 == 1'b0, "R8 no overrun", {63'b0, ovr1}, 64'h0);

        // R9: overwrite of unsent sample
        apply(32'h789A_BCDE, 1'b0, '0);
        capture(5, 32'h0123_4567, 12, 32'hFEDC_BA98, line, f1, f2, o1, fs);
        chk(line == {32'h789A_BCDE, sa}, "R9 current frame intact", line, {32'h789A_BCDE, sa});
        chk(ovr1 == 1'b1, "R9 overrun set", {63'b0, ovr1}, 64'h1);
        capture(-1, '0, -1, '0, line, f1, f2, o1, fs);
        chk(line == {32'hFEDC_BA98, sa}, "R9 newest sample wins", line, {32'hFEDC_BA98, sa});
        chk(ovr1 == 1'b1, "R9 overrun sticky", {63'b0, ovr1}, 64'h1);

        // R4: no frame without a new sample
        n = 0;
        repeat (600) begin @(negedge clk); if (fsync1 || oe1) n++; end
        chk(n == 0, "R4 idle without sample", 64'(n), 64'h0);

        // R7: data-valid pulse lengths (master short, slave long)
        @(negedge clk);
        m_valid = 1'b1; s_valid = 1'b1;
        c1 = 0; c2 = 0;
        @(negedge clk);
        m_valid = 1'b0; s_valid = 1'b0;
        if (dv1) c1++;
        if (dv2) c2++;
        repeat (8) begin @(negedge clk); if (dv1) c1++; if (dv2) c2++; end
        chk(c1 == 2, "R7 short dv pulse", 64'(c1), 64'd2);
        chk(c2 == 4, "R7 long dv pulse", 64'(c2), 64'd4);

        // R3: exclusive ownership across the whole run
        chk(overlap_cnt == 0, "R3 no double drive", 64'(overlap_cnt), 64'h0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule